// File: doc/BRIEF.md
# Serial Flash Status Register with Protection Lock

This block holds the volatile status byte of a serial NOR flash device and the logic that guards its protection fields. A command decoder presents a one-cycle status write request with a data byte. A program/erase sequencer drives the busy and auto-increment indicators and sets or clears the write-enable latch. The external write-protect pin, which is active low, decides whether the lock bit may change.

The block returns the composed status byte for read commands and the current protection level for the address-range decoder. It also gives a flag, combinational in the request cycle, that tells the decoder whether the write was taken.

The write request is a single-cycle strobe with no back-pressure. A request that is not accepted is dropped, and the decoder is not expected to retry it. The busy and auto-increment inputs and the write-protect pin are plain level signals.

Top module: `nvm_status_reg`

## Requirements
- R1: The status byte is laid out as follows: bit 0 is busy, bit 1 is the write-enable latch, bits 4:2 are the protection level (bit 2 is its LSB), bit 5 is reserved, bit 6 is the auto-increment mode flag, and bit 7 is the protection lock.
- R2: After power-on reset the status byte reads 8'h1C: the protection level is 3'b111 and every other bit is 0.
- R3: `wr_accept` is high in the cycle of a request only when `wr_req` is 1, the write-enable latch is 1 and `busy_in` is 0, subject also to R6.
- R4: An accepted write loads the protection level from `wr_data[4:2]` when the lock is 0. It loads the lock from `wr_data[7]` when `wp_n` is 1. The new values are visible after the clock edge.
- R5: While the lock is 1, the protection level does not change. This holds even for an accepted write that clears the lock.
- R6: While `wp_n` is 0, the lock bit does not change. If the lock is 1 and `wp_n` is 0, the whole write is rejected and `wr_accept` stays 0.
- R7: An accepted write clears the write-enable latch at the same edge that updates the register. This takes priority over `wel_set`.
- R8: `wel_set` sets the latch and `wel_clr` clears it. When both are high, the clear wins.
- R9: While `busy_in` is 1, write requests, `wel_set` and `wel_clr` are ignored, and bits 7, 4:2 and 1 hold their values.
- R10: Bit 5 always reads 0. Written values for bits 0, 1, 5 and 6 are discarded.
- R11: Bits 0 and 6 follow `busy_in` and `aai_in` in the same cycle, with no register delay.
- R12: `prot_level` always equals status bits 4:2.
- R13: Asserting `por_n` low returns the register to 8'h1C at once, without waiting for a clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| por_n | input | 1 | Asynchronous power-on reset, active low |
| wr_req | input | 1 | One-cycle status write request |
| wr_data | input | 8 | Byte to write |
| wel_set | input | 1 | Set the write-enable latch |
| wel_clr | input | 1 | Clear the write-enable latch |
| busy_in | input | 1 | Internal program/erase in progress |
| aai_in | input | 1 | Auto-address-increment programming active |
| wp_n | input | 1 | Write-protect pin, active low |
| status_out | output | 8 | Composed status byte |
| prot_level | output | 3 | Current protection level |
| wr_accept | output | 1 | Current request is accepted |

## Verification
The bench builds the block with its default parameters: a three-bit protection level and a power-up level of all ones. With these defaults every value of the level field and the full 8'h1C reset pattern can be checked directly. Directed sequences walk the lock and the pin through all four combinations. They also cover a write that clears the lock while the level is held, the priority of the latch set and clear against each other and against an accepted write, and a reset applied between clock edges.

// File: rtl/nvm_sr_pkg.sv
package nvm_sr_pkg;
  localparam int SR_W      = 8;
  localparam int LVL_W     = 3;
  localparam int POS_BUSY  = 0;
  localparam int POS_WEL   = 1;
  localparam int POS_LVL   = 2;
  localparam int POS_RSVD  = 5;
  localparam int POS_AAI   = 6;
  localparam int POS_LOCK  = 7;
  localparam int LVL_HI    = POS_LVL + LVL_W - 1;

  typedef struct packed {
    logic             lock;
    logic [LVL_W-1:0] level;
  } prot_state_t;
endpackage

// File: rtl/sr_write_gate.sv
module sr_write_gate (
  input  logic wr_req,
  input  logic wel_q,
  input  logic busy_in,
  input  logic lock_q,
  input  logic wp_n,
  output logic accept
);
  logic pin_blocks;

  always_comb begin
    pin_blocks = lock_q & ~wp_n;
    accept     = wr_req & wel_q & ~busy_in & ~pin_blocks;
  end
endmodule

// File: rtl/sr_wel_latch.sv
module sr_wel_latch (
  input  logic clk,
  input  logic por_n,
  input  logic busy_in,
  input  logic wel_set,
  input  logic wel_clr,
  input  logic accept,
  output logic wel_q
);
  logic wel_d;

  always_comb begin
    wel_d = wel_q;
    if (accept)        wel_d = 1'b0;
    else if (!busy_in) begin
      if (wel_clr)      wel_d = 1'b0;
      else if (wel_set) wel_d = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge por_n) begin
    if (!por_n) wel_q <= 1'b0;
    else        wel_q <= wel_d;
  end
endmodule

// File: rtl/sr_prot_bits.sv
module sr_prot_bits
  import nvm_sr_pkg::*;
#(
  parameter logic [LVL_W-1:0] RESET_LEVEL = '1
) (
  input  logic              clk,
  input  logic              por_n,
  input  logic              accept,
  input  logic              wp_n,
  input  logic [SR_W-1:0]   wr_data,
  output prot_state_t       prot_q
);
  prot_state_t prot_d;

  always_comb begin
    prot_d = prot_q;
    if (accept) begin
      if (!prot_q.lock) prot_d.level = wr_data[LVL_HI:POS_LVL];
      if (wp_n)         prot_d.lock  = wr_data[POS_LOCK];
    end
  end

  always_ff @(posedge clk or negedge por_n) begin
    if (!por_n) begin
      prot_q.lock  <= 1'b0;
      prot_q.level <= RESET_LEVEL;
    end else begin
      prot_q <= prot_d;
    end
  end
endmodule

// File: rtl/sr_compose.sv
module sr_compose
  import nvm_sr_pkg::*;
(
  input  logic            busy_in,
  input  logic            aai_in,
  input  logic            wel_q,
  input  prot_state_t     prot_q,
  output logic [SR_W-1:0] status
);
  always_comb begin
    status           = '0;
    status[POS_BUSY] = busy_in;
    status[POS_WEL]  = wel_q;
    status[LVL_HI:POS_LVL] = prot_q.level;
    status[POS_RSVD] = 1'b0;
    status[POS_AAI]  = aai_in;
    status[POS_LOCK] = prot_q.lock;
  end
endmodule

// File: rtl/nvm_status_reg.sv
module nvm_status_reg
  import nvm_sr_pkg::*;
#(
  parameter logic [LVL_W-1:0] RESET_LEVEL = '1
) (
  input  logic             clk,
  input  logic             por_n,
  input  logic             wr_req,
  input  logic [SR_W-1:0]  wr_data,
  input  logic             wel_set,
  input  logic             wel_clr,
  input  logic             busy_in,
  input  logic             aai_in,
  input  logic             wp_n,
  output logic [SR_W-1:0]  status_out,
  output logic [LVL_W-1:0] prot_level,
  output logic             wr_accept
);
  logic        wel_q;
  logic        accept;
  prot_state_t prot_q;

  sr_write_gate u_gate (
    .wr_req (wr_req),
    .wel_q  (wel_q),
    .busy_in(busy_in),
    .lock_q (prot_q.lock),
    .wp_n   (wp_n),
    .accept (accept)
  );

  sr_wel_latch u_wel (
    .clk    (clk),
    .por_n  (por_n),
    .busy_in(busy_in),
    .wel_set(wel_set),
    .wel_clr(wel_clr),
    .accept (accept),
    .wel_q  (wel_q)
  );

  sr_prot_bits #(.RESET_LEVEL(RESET_LEVEL)) u_prot (
    .clk    (clk),
    .por_n  (por_n),
    .accept (accept),
    .wp_n   (wp_n),
    .wr_data(wr_data),
    .prot_q (prot_q)
  );

  sr_compose u_comp (
    .busy_in(busy_in),
    .aai_in (aai_in),
    .wel_q  (wel_q),
    .prot_q (prot_q),
    .status (status_out)
  );

  assign prot_level = prot_q.level;
  assign wr_accept  = accept;
endmodule

// File: rtl/nvm_status_reg_chk.sv
module nvm_status_reg_chk
  import nvm_sr_pkg::*;
(
  input logic             clk,
  input logic             por_n,
  input logic             wr_req,
  input logic             busy_in,
  input logic             aai_in,
  input logic             wp_n,
  input logic [SR_W-1:0]  status_out,
  input logic [LVL_W-1:0] prot_level,
  input logic             wr_accept
);
  a_r5_level_held_when_locked: assert property (@(posedge clk) disable iff (!por_n)
    status_out[POS_LOCK] |=> $stable(prot_level));

  a_r6_pin_freezes_lock: assert property (@(posedge clk) disable iff (!por_n)
    !wp_n |=> $stable(status_out[POS_LOCK]));

  a_r6_pin_rejects_locked: assert property (@(posedge clk) disable iff (!por_n)
    (!wp_n && status_out[POS_LOCK]) |-> !wr_accept);

  a_r3_accept_needs_wel: assert property (@(posedge clk) disable iff (!por_n)
    wr_accept |-> (wr_req && status_out[POS_WEL] && !busy_in));

  a_r7_accept_clears_wel: assert property (@(posedge clk) disable iff (!por_n)
    wr_accept |=> !status_out[POS_WEL]);

  a_r9_busy_freezes: assert property (@(posedge clk) disable iff (!por_n)
    busy_in |=> ($stable(status_out[LVL_HI:POS_WEL]) && $stable(status_out[POS_LOCK])));

  a_r10_reserved_zero: assert property (@(posedge clk) disable iff (!por_n)
    status_out[POS_RSVD] == 1'b0);

  a_r11_live_flags: assert property (@(posedge clk) disable iff (!por_n)
    (status_out[POS_BUSY] == busy_in) && (status_out[POS_AAI] == aai_in));

  a_r12_level_mirror: assert property (@(posedge clk) disable iff (!por_n)
    prot_level == status_out[LVL_HI:POS_LVL]);
endmodule

bind nvm_status_reg nvm_status_reg_chk u_chk (
  .clk       (clk),
  .por_n     (por_n),
  .wr_req    (wr_req),
  .busy_in   (busy_in),
  .aai_in    (aai_in),
  .wp_n      (wp_n),
  .status_out(status_out),
  .prot_level(prot_level),
  .wr_accept (wr_accept)
);

// File: tb/nvm_status_reg_test.sv
`timescale 1ns/1ps
module nvm_status_reg_test;
  logic       clk = 1'b0;
  logic       por_n = 1'b0;
  logic       wr_req = 1'b0;
  logic [7:0] wr_data = 8'h00;
  logic       wel_set = 1'b0;
  logic       wel_clr = 1'b0;
  logic       busy_in = 1'b0;
  logic       aai_in = 1'b0;
  logic       wp_n = 1'b1;
  logic [7:0] status_out;
  logic [2:0] prot_level;
  logic       wr_accept;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  nvm_status_reg uut (
    .clk(clk), .por_n(por_n), .wr_req(wr_req), .wr_data(wr_data),
    .wel_set(wel_set), .wel_clr(wel_clr), .busy_in(busy_in), .aai_in(aai_in),
    .wp_n(wp_n), .status_out(status_out), .prot_level(prot_level), .wr_accept(wr_accept)
  );

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic set_wel();
    @(negedge clk); wel_set = 1'b1;
    @(negedge clk); wel_set = 1'b0;
  endtask

  task automatic write_sr(input logic [7:0] d, input logic pin, input logic exp_acc, input string req);
    @(negedge clk);
    wr_req = 1'b1; wr_data = d; wp_n = pin;
    #1 chk(req, {7'd0, wr_accept}, {7'd0, exp_acc});
    @(negedge clk);
    wr_req = 1'b0; wp_n = 1'b1;
  endtask

  task automatic t_reset();
    chk("R2", status_out, 8'h1C);
    chk("R12", {5'd0, prot_level}, 8'h07);
    chk("R1", {7'd0, wr_accept}, 8'h00);
  endtask

  task automatic t_no_wel();
    write_sr(8'h00, 1'b1, 1'b0, "R3");
    chk("R3", status_out, 8'h1C);
  endtask

  task automatic t_basic_write();
    set_wel();
    chk("R8", status_out, 8'h1E);
    write_sr(8'h6B, 1'b1, 1'b1, "R3");
    chk("R10", status_out, 8'h08);
    chk("R4", {5'd0, prot_level}, 8'h02);
  endtask

  task automatic t_lock();
    set_wel();
    write_sr(8'h94, 1'b1, 1'b1, "R4");
    chk("R4", status_out, 8'h94);
    set_wel();
    write_sr(8'h9C, 1'b1, 1'b1, "R5");
    chk("R5", status_out, 8'h94);
  endtask

  task automatic t_pin_locked();
    set_wel();
    write_sr(8'h00, 1'b0, 1'b0, "R6");
    chk("R6", status_out, 8'h96);
    write_sr(8'h00, 1'b1, 1'b1, "R4");
    chk("R5", status_out, 8'h14);
  endtask

  task automatic t_pin_unlocked();
    set_wel();
    write_sr(8'h88, 1'b0, 1'b1, "R6");
    chk("R6", status_out, 8'h08);
  endtask

  task automatic t_busy();
    set_wel();
    @(negedge clk); busy_in = 1'b1;
    #1 chk("R11", status_out, 8'h0B);
    @(negedge clk); wel_clr = 1'b1;
    @(negedge clk); wel_clr = 1'b0;
    wr_req = 1'b1; wr_data = 8'h1C;
    #1 chk("R9", {7'd0, wr_accept}, 8'h00);
    @(negedge clk); wr_req = 1'b0; busy_in = 1'b0;
    #1 chk("R9", status_out, 8'h0A);
    aai_in = 1'b1;
    #1 chk("R11", status_out, 8'h4A);
    aai_in = 1'b0;
  endtask

  task automatic t_wel_priority();
    @(negedge clk); wel_set = 1'b1; wel_clr = 1'b1;
    @(negedge clk); wel_set = 1'b0; wel_clr = 1'b0;
    chk("R8", status_out, 8'h08);
    set_wel();
    @(negedge clk); wr_req = 1'b1; wr_data = 8'h04; wel_set = 1'b1;
    @(negedge clk); wr_req = 1'b0; wel_set = 1'b0;
    chk("R7", status_out, 8'h04);
  endtask

  task automatic t_por();
    set_wel();
    @(negedge clk); #2 por_n = 1'b0;
    #1 chk("R13", status_out, 8'h1C);
    @(negedge clk); por_n = 1'b1;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    por_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_no_wel();
    t_basic_write();
    t_lock();
    t_pin_locked();
    t_pin_unlocked();
    t_busy();
    t_wel_priority();
    t_por();
    done = 1'b1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (5000) @(posedge clk);
        errors++; checks++;
        $display("FAIL watchdog actual=timeout expected=done");
      end
    join_any
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule